// File: doc/BRIEF.md
# Remote Interrupt Dispatch Unit

This unit sits between a master core and a slave core. The master uses it to raise coded interrupts on the slave and to follow each one until it completes. The master issues a raise command that carries a code. The unit then drives an interrupt-pending line and a code bus toward the slave. On the slave side, the unit looks up a handler address for the code in a vector table. It issues a one-cycle redirect to the slave fetch unit and waits for a handler-complete strobe. When the strobe arrives, it raises the serviced line.

The exchange is a four-phase handshake. Pending rises, serviced rises, pending falls, serviced falls. Only after that can a new interrupt start. The master loads the vector table through its own write port. The slave has no write path into the table.

Top module: `remote_irq_dispatch`

## Requirements
- R1: After reset, `ints_o`, `serviced_o`, `redirect_o`, `busy_o` and `done_o` are all low.
- R2: A `raise_i` that is sampled while `busy_o` is low sets `ints_o` on the next clock. The same edge latches `raise_code_i` into `intscode_o`.
- R3: `intscode_o` stays stable while `ints_o` is high. `busy_o` is high whenever `ints_o` or `serviced_o` is high. A `raise_i` sampled while busy has no effect on `ints_o` or `intscode_o`.
- R4: The edge after `ints_o` is first seen high drives `redirect_o` high for exactly one cycle. In that cycle, `redirect_addr_o` holds the table entry indexed by `intscode_o`.
- R5: There is exactly one redirect for each assertion of `ints_o`, however many cycles `ints_o` stays high.
- R6: `serviced_o` rises on the clock after a `handler_done_i` that arrives once the redirect has been issued. A `handler_done_i` that arrives while no interrupt is in its handler has no effect.
- R7: The clock after `serviced_o` is seen with `ints_o` high, `ints_o` drops. `done_o` is high for that one cycle.
- R8: The clock after `ints_o` is seen low, `serviced_o` drops and `busy_o` clears.
- R9: A table write with `tbl_we_i` high replaces entry `tbl_idx_i` with `tbl_data_i` on the next clock. All other entries are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 1 | Master request to raise an interrupt |
| raise_code_i | input | CODE_W | Code for the interrupt being raised |
| busy_o | output | 1 | A handshake is in progress; raises are refused |
| done_o | output | 1 | One-cycle completion pulse to the master |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_idx_i | input | CODE_W | Vector table entry to write |
| tbl_data_i | input | ADDR_W | Handler address to store |
| ints_o | output | 1 | Interrupt pending toward the slave |
| intscode_o | output | CODE_W | Latched interrupt code |
| redirect_o | output | 1 | One-cycle redirect to the slave fetch unit |
| redirect_addr_o | output | ADDR_W | Handler address for the redirect |
| handler_done_i | input | 1 | Slave strobe marking the end of the handler |
| serviced_o | output | 1 | Handler-complete indication toward the master |

## Verification
The bench builds the unit with its defaults: a 4-bit code and 32-bit addresses. With those values all 16 vector entries can be loaded and dispatched in full, each with an address computed from its index. The sweep runs every code through the complete four-phase handshake with handler durations that vary per code. Each run also tries a refused raise in both busy phases. A stray handler strobe is sent while idle, and one table entry is rewritten mid-run to confirm that its neighbours stay intact.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    SL_IDLE    = 2'd0,
    SL_HANDLER = 2'd1,
    SL_DONE    = 2'd2
  } slave_state_e;
endpackage

// File: rtl/rid_vec_table.sv
module rid_vec_table #(
  parameter int CODE_W = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] widx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [CODE_W-1:0] ridx_i,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int NUM_VEC = 1 << CODE_W;

  logic [ADDR_W-1:0] vec_q [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 vec_q[g] <= '0;
      else if (we_i && widx_i == CODE_W'(g))       vec_q[g] <= wdata_i;
    end
  end

  assign rdata_o = vec_q[ridx_i];

  assert_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (ridx_i == widx_i) |=> (rdata_o == $past(wdata_i)) || (ridx_i != $past(ridx_i)));
endmodule

// File: rtl/rid_master_ctrl.sv
module rid_master_ctrl #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  logic [CODE_W-1:0] raise_code_i,
  input  logic              serviced_i,
  output logic              ints_o,
  output logic [CODE_W-1:0] intscode_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              ints_q;
  logic [CODE_W-1:0] code_q;
  logic              accept;

  assign busy_o = ints_q | serviced_i;
  assign accept = raise_i & ~busy_o;
  assign done_o = ints_q & serviced_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ints_q <= 1'b0;
      code_q <= '0;
    end else if (accept) begin
      ints_q <= 1'b1;
      code_q <= raise_code_i;
    end else if (done_o) begin
      ints_q <= 1'b0;
    end
  end

  assign ints_o     = ints_q;
  assign intscode_o = code_q;

  assert_code_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ints_q |=> !ints_q || $stable(code_q));
  assert_refuse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i && serviced_i && !ints_q |=> !ints_q);
  assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ints_q && serviced_i |=> !ints_q);
endmodule

// File: rtl/rid_slave_ctrl.sv
module rid_slave_ctrl
  import rid_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ints_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  input  logic              handler_done_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              serviced_o
);
  slave_state_e      state_q;
  logic              redir_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SL_IDLE;
      redir_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      redir_q <= 1'b0;
      unique case (state_q)
        SL_IDLE: if (ints_i) begin
          redir_q <= 1'b1;
          addr_q  <= vec_addr_i;
          state_q <= SL_HANDLER;
        end
        SL_HANDLER: if (handler_done_i) state_q <= SL_DONE;
        SL_DONE:    if (!ints_i)        state_q <= SL_IDLE;
        default:                        state_q <= SL_IDLE;
      endcase
    end
  end

  assign redirect_o      = redir_q;
  assign redirect_addr_o = addr_q;
  assign serviced_o      = (state_q == SL_DONE);

  assert_redirect_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_q |=> !redir_q);
  assert_no_redirect_serviced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serviced_o |-> !redir_q);
  assert_serviced_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(serviced_o) |-> $past(handler_done_i));
  assert_serviced_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serviced_o && !ints_i |=> !serviced_o);
endmodule

// File: rtl/remote_irq_dispatch.sv
module remote_irq_dispatch #(
  parameter int CODE_W = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  logic [CODE_W-1:0] raise_code_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              tbl_we_i,
  input  logic [CODE_W-1:0] tbl_idx_i,
  input  logic [ADDR_W-1:0] tbl_data_i,
  output logic              ints_o,
  output logic [CODE_W-1:0] intscode_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  input  logic              handler_done_i,
  output logic              serviced_o
);
  logic              ints;
  logic              serviced;
  logic [CODE_W-1:0] code;
  logic [ADDR_W-1:0] vec_addr;

  rid_master_ctrl #(.CODE_W(CODE_W)) u_master (
    .clk_i, .rst_ni, .raise_i, .raise_code_i,
    .serviced_i (serviced),
    .ints_o     (ints),
    .intscode_o (code),
    .busy_o, .done_o
  );

  rid_vec_table #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_table (
    .clk_i, .rst_ni,
    .we_i    (tbl_we_i),
    .widx_i  (tbl_idx_i),
    .wdata_i (tbl_data_i),
    .ridx_i  (code),
    .rdata_o (vec_addr)
  );

  rid_slave_ctrl #(.ADDR_W(ADDR_W)) u_slave (
    .clk_i, .rst_ni,
    .ints_i     (ints),
    .vec_addr_i (vec_addr),
    .handler_done_i,
    .redirect_o, .redirect_addr_o,
    .serviced_o (serviced)
  );

  assign ints_o     = ints;
  assign intscode_o = code;
  assign serviced_o = serviced;

  assert_redirect_needs_ints_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(redirect_o) |-> ints);
  assert_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ints || serviced) |-> busy_o);
endmodule

// File: tb/remote_irq_dispatch_tb.sv
`timescale 1ns/1ps
module remote_irq_dispatch_tb;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 32;
  localparam int NV = 1 << CODE_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic raise_i = 1'b0, tbl_we_i = 1'b0, handler_done_i = 1'b0;
  logic [CODE_W-1:0] raise_code_i = '0, tbl_idx_i = '0;
  logic [ADDR_W-1:0] tbl_data_i = '0;
  logic busy_o, done_o, ints_o, redirect_o, serviced_o;
  logic [CODE_W-1:0] intscode_o;
  logic [ADDR_W-1:0] redirect_addr_o;

  int compared = 0, mismatched = 0, redir_cnt = 0, cycles = 0;
  logic [ADDR_W-1:0] model [NV];

  always #2 clk = ~clk;

  remote_irq_dispatch #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni, .raise_i, .raise_code_i, .busy_o, .done_o,
    .tbl_we_i, .tbl_idx_i, .tbl_data_i, .ints_o, .intscode_o,
    .redirect_o, .redirect_addr_o, .handler_done_i, .serviced_o
  );

  always @(negedge clk) if (rst_ni && redirect_o) redir_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] vec_of(int i);
    return 32'h8000_0000 + 32'(i) * 32'h0011_0040;
  endfunction

  task automatic wr_tbl(int idx, logic [ADDR_W-1:0] d);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_idx_i = CODE_W'(idx); tbl_data_i = d;
    @(negedge clk);
    tbl_we_i = 1'b0;
    model[idx] = d;
  endtask

  task automatic run_irq(int code, int hold);
    int r0;
    @(negedge clk);
    raise_i = 1'b1; raise_code_i = CODE_W'(code);
    r0 = redir_cnt;
    @(negedge clk);
    raise_i = 1'b0;
    chk("R2 ints", 32'(ints_o), 32'd1);
    chk("R2 code", 32'(intscode_o), 32'(code));
    chk("R3 busy", 32'(busy_o), 32'd1);
    @(negedge clk);
    chk("R4 redirect", 32'(redirect_o), 32'd1);
    chk("R4 addr", redirect_addr_o, model[code]);
    // refused raise with another code while handler runs
    raise_i = 1'b1; raise_code_i = CODE_W'(code ^ 5);
    @(negedge clk);
    raise_i = 1'b0;
    chk("R3 code held", 32'(intscode_o), 32'(code));
    for (int k = 0; k < hold; k++) @(negedge clk);
    chk("R6 no early serviced", 32'(serviced_o), 32'd0);
    chk("R5 one redirect", 32'(redir_cnt - r0), 32'd1);
    handler_done_i = 1'b1;
    @(negedge clk);
    handler_done_i = 1'b0;
    chk("R6 serviced", 32'(serviced_o), 32'd1);
    chk("R7 done", 32'(done_o), 32'd1);
    @(negedge clk);
    chk("R7 ints drop", 32'(ints_o), 32'd0);
    chk("R8 still serviced", 32'(serviced_o), 32'd1);
    raise_i = 1'b1; // refused: serviced still high
    @(negedge clk);
    raise_i = 1'b0;
    chk("R8 serviced drop", 32'(serviced_o), 32'd0);
    chk("R8 busy clear", 32'(busy_o), 32'd0);
    chk("R3 refused in serviced", 32'(ints_o), 32'd0);
    chk("R5 total", 32'(redir_cnt - r0), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ints", 32'(ints_o), 32'd0);
    chk("R1 serviced", 32'(serviced_o), 32'd0);
    chk("R1 redirect", 32'(redirect_o), 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) wr_tbl(i, vec_of(i));
    // stray handler strobe while idle
    @(negedge clk); handler_done_i = 1'b1;
    @(negedge clk); handler_done_i = 1'b0;
    @(negedge clk);
    chk("R6 stray strobe", 32'(serviced_o), 32'd0);
    for (int i = 0; i < NV; i++) run_irq(i, (i * 3) % 7);
    run_irq(9, 40);
    wr_tbl(5, 32'hDEAD_0005);
    run_irq(5, 1);
    run_irq(6, 0);
    run_irq(4, 2);
    chk("R9 neighbour", model[6], vec_of(6));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule